// File: doc/BRIEF.md
# Keyed Amplitude Envelope Scaler

This block sits between a digital waveform source and a DAC. It multiplies each 12-bit sample by a 12-bit amplitude factor, so the signal can be switched on and off with a linear envelope rather than a hard step. The envelope is a 12-bit saturating up/down counter. A programmable 8-bit down-counting prescaler advances it, and the prescaler sets how many clock cycles separate two envelope steps.

In automatic mode a single keying input steers the envelope. While the input is high the envelope climbs to full scale and holds there. While it is low the envelope falls to zero and holds there. In manual mode a fixed factor supplied on a port replaces the envelope. When scaling is disabled, the sample skips the multiplier and passes through unchanged.

Top module: `envscale_top`

## Requirements
- R1: With a countdown value N of 3 or more, the prescaler issues one envelope step every N+1 clock cycles. The first step lands on the (N+1)-th rising edge after the last reset edge.
- R2: A new countdown value is taken only when the prescaler reloads. The step that is already under way keeps the old period, and every later step uses the new one.
- R3: If the countdown value taken at a reload is below 3, no envelope steps occur and the envelope stays constant. The prescaler keeps sampling the countdown port on every cycle, and the first step arrives N+2 edges after a legal value N appears.
- R4: While keyIn is 1, each step raises envLevel by one. When envLevel reaches 4095 it holds there and never wraps.
- R5: While keyIn is 0, each step lowers envLevel by one. When envLevel reaches 0 it holds there and never wraps.
- R6: A change on keyIn takes effect at the very next step, including a step in the same cycle as the change.
- R7: When autoMode is 1, the factor on scaleNow is envLevel. When autoMode is 0, scaleNow is manualScale.
- R8: When keyEnable is 1, sampleOut on the next clock edge is (sampleIn × scaleNow) >> 12, computed unsigned.
- R9: When keyEnable is 0, sampleOut on the next clock edge equals sampleIn.
- R10: A synchronous active-high rst clears envLevel and sampleOut to 0 and loads the prescaler from rateCount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| keyEnable | input | 1 | 1 routes the sample through the multiplier, 0 bypasses it |
| autoMode | input | 1 | 1 takes the factor from the envelope, 0 from manualScale |
| keyIn | input | 1 | On/off keying: 1 ramps up, 0 ramps down |
| rateCount | input | 8 | Prescaler countdown value N |
| manualScale | input | 12 | Fixed amplitude factor used in manual mode |
| sampleIn | input | 12 | Unsigned input sample |
| sampleOut | output | 12 | Registered scaled or bypassed sample |
| envLevel | output | 12 | Current envelope counter value |
| scaleNow | output | 12 | Factor currently applied to the multiplier |

## Verification
Two events can fall in the same cycle: an envelope step from the prescaler and a reversal of keyIn. A second pair is a rewrite of the countdown value in the cycle of a reload. The bench works out the step phase from the edge count since reset. It flips keyIn in the cycle where a step is pending and expects the envelope to move in the new direction on the next edge. It also rewrites rateCount right after a reload and expects exactly one more step at the old period before the new period applies.

// File: rtl/envscale_pkg.sv
package envscale_pkg;
  // Step strobes the control side hands to the datapath
  typedef struct packed {
    logic stepUp;
    logic stepDown;
  } envStrobe_t;
endpackage

// File: rtl/envscale_rate.sv
module envscale_rate #(
  parameter int RATE_W      = 8,
  parameter int STALL_BELOW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rateCount,
  output logic              stepPulse
);
  localparam logic [RATE_W-1:0] STALL_LIM = RATE_W'(STALL_BELOW);

  logic [RATE_W-1:0] downCnt;
  logic [RATE_W-1:0] heldN;
  logic              stalled;
  logic              reloadNow;

  assign stalled   = heldN < STALL_LIM;
  assign stepPulse = !stalled && (downCnt == '0);
  // While stalled, sample the port every cycle so a legal value is picked up
  assign reloadNow = stalled || (downCnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      downCnt <= rateCount;
      heldN   <= rateCount;
    end else if (reloadNow) begin
      downCnt <= rateCount;
      heldN   <= rateCount;
    end else begin
      downCnt <= downCnt - 1'b1;
    end
  end
endmodule

// File: rtl/envscale_ctrl.sv
module envscale_ctrl
  import envscale_pkg::*;
#(
  parameter int RATE_W      = 8,
  parameter int STALL_BELOW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rateCount,
  input  logic              keyIn,
  output envStrobe_t        strobe
);
  logic stepPulse;

  envscale_rate #(
    .RATE_W     (RATE_W),
    .STALL_BELOW(STALL_BELOW)
  ) rateGen (
    .clk      (clk),
    .rst      (rst),
    .rateCount(rateCount),
    .stepPulse(stepPulse)
  );

  // The direction is sampled in the cycle of the step itself
  always_comb begin
    strobe.stepUp   = stepPulse && keyIn;
    strobe.stepDown = stepPulse && !keyIn;
  end
endmodule

// File: rtl/envscale_dp.sv
module envscale_dp
  import envscale_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int SCALE_W  = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  envStrobe_t          strobe,
  input  logic                autoMode,
  input  logic                keyEnable,
  input  logic [SCALE_W-1:0]  manualScale,
  input  logic [SAMPLE_W-1:0] sampleIn,
  output logic [SAMPLE_W-1:0] sampleOut,
  output logic [SCALE_W-1:0]  envLevel,
  output logic [SCALE_W-1:0]  scaleNow
);
  localparam int                 PROD_W   = SAMPLE_W + SCALE_W;
  localparam logic [SCALE_W-1:0] ENV_FULL = '1;
  localparam logic [SCALE_W-1:0] ENV_ZERO = '0;

  logic [SCALE_W-1:0]  envReg;
  logic [PROD_W-1:0]   product;
  logic [SAMPLE_W-1:0] scaled;
  logic [SAMPLE_W-1:0] nextOut;

  // Saturating envelope counter
  always_ff @(posedge clk) begin
    if (rst) begin
      envReg <= ENV_ZERO;
    end else if (strobe.stepUp && envReg != ENV_FULL) begin
      envReg <= envReg + 1'b1;
    end else if (strobe.stepDown && envReg != ENV_ZERO) begin
      envReg <= envReg - 1'b1;
    end
  end

  assign envLevel = envReg;
  assign scaleNow = autoMode ? envReg : manualScale;

  // Unsigned multiply, keep the upper SAMPLE_W bits
  assign product = PROD_W'(sampleIn) * PROD_W'(scaleNow);
  assign scaled  = product[PROD_W-1:SCALE_W];
  assign nextOut = keyEnable ? scaled : sampleIn;

  always_ff @(posedge clk) begin
    if (rst) sampleOut <= '0;
    else     sampleOut <= nextOut;
  end
endmodule

// File: rtl/envscale_top.sv
module envscale_top
  import envscale_pkg::*;
#(
  parameter int SAMPLE_W    = 12,
  parameter int SCALE_W     = 12,
  parameter int RATE_W      = 8,
  parameter int STALL_BELOW = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                keyEnable,
  input  logic                autoMode,
  input  logic                keyIn,
  input  logic [RATE_W-1:0]   rateCount,
  input  logic [SCALE_W-1:0]  manualScale,
  input  logic [SAMPLE_W-1:0] sampleIn,
  output logic [SAMPLE_W-1:0] sampleOut,
  output logic [SCALE_W-1:0]  envLevel,
  output logic [SCALE_W-1:0]  scaleNow
);
  envStrobe_t strobe;

  envscale_ctrl #(
    .RATE_W     (RATE_W),
    .STALL_BELOW(STALL_BELOW)
  ) ctrl (
    .clk      (clk),
    .rst      (rst),
    .rateCount(rateCount),
    .keyIn    (keyIn),
    .strobe   (strobe)
  );

  envscale_dp #(
    .SAMPLE_W(SAMPLE_W),
    .SCALE_W (SCALE_W)
  ) dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .autoMode   (autoMode),
    .keyEnable  (keyEnable),
    .manualScale(manualScale),
    .sampleIn   (sampleIn),
    .sampleOut  (sampleOut),
    .envLevel   (envLevel),
    .scaleNow   (scaleNow)
  );
endmodule

// File: rtl/envscale_chk.sv
module envscale_chk #(
  parameter int SAMPLE_W = 12,
  parameter int SCALE_W  = 12
) (
  input logic                clk,
  input logic                rst,
  input logic                keyEnable,
  input logic                keyIn,
  input logic [SAMPLE_W-1:0] sampleIn,
  input logic [SAMPLE_W-1:0] sampleOut,
  input logic [SCALE_W-1:0]  envLevel
);
  localparam logic [SCALE_W-1:0] TOP = '1;

  // R4: envelope never falls while keying is high
  p_rise_only_r4: assert property (@(posedge clk) disable iff (rst)
    keyIn |=> envLevel >= $past(envLevel));

  // R4: full scale holds while keying stays high
  p_top_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (keyIn && envLevel == TOP) |=> envLevel == TOP);

  // R5: envelope never rises while keying is low
  p_fall_only_r5: assert property (@(posedge clk) disable iff (rst)
    !keyIn |=> envLevel <= $past(envLevel));

  // R5: zero holds while keying stays low
  p_bottom_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!keyIn && envLevel == '0) |=> envLevel == '0);

  // R9: bypass passes the sample through one cycle later
  p_bypass_r9: assert property (@(posedge clk) disable iff (rst)
    !keyEnable |=> sampleOut == $past(sampleIn));
endmodule

bind envscale_top envscale_chk #(
  .SAMPLE_W(SAMPLE_W),
  .SCALE_W (SCALE_W)
) chk (
  .clk      (clk),
  .rst      (rst),
  .keyEnable(keyEnable),
  .keyIn    (keyIn),
  .sampleIn (sampleIn),
  .sampleOut(sampleOut),
  .envLevel (envLevel)
);

// File: tb/envscale_top_test.sv
`timescale 1ns/1ps
module envscale_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        keyEnable = 1'b1;
  logic        autoMode = 1'b1;
  logic        keyIn = 1'b0;
  logic [7:0]  rateCount = 8'd3;
  logic [11:0] manualScale = '0;
  logic [11:0] sampleIn = '0;
  logic [11:0] sampleOut, envLevel, scaleNow;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  envscale_top uut (
    .clk(clk), .rst(rst), .keyEnable(keyEnable), .autoMode(autoMode),
    .keyIn(keyIn), .rateCount(rateCount), .manualScale(manualScale),
    .sampleIn(sampleIn), .sampleOut(sampleOut), .envLevel(envLevel),
    .scaleNow(scaleNow)
  );

  // {enable, sample, manual factor, expected output}
  localparam logic [36:0] VEC [8] = '{
    {1'b1, 12'd4095, 12'd4095, 12'd4094},
    {1'b1, 12'd2048, 12'd2048, 12'd1024},
    {1'b1, 12'd1000, 12'd0,    12'd0},
    {1'b1, 12'd4095, 12'd1,    12'd0},
    {1'b1, 12'd3000, 12'd2048, 12'd1500},
    {1'b1, 12'd100,  12'd4095, 12'd99},
    {1'b0, 12'd1234, 12'd0,    12'd1234},
    {1'b0, 12'd4095, 12'd2048, 12'd4095}
  };

  task automatic check(string req, logic [11:0] act, logic [11:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edges(int k);
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(5.0 * 190000);
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    // R10 reset state
    rateCount = 8'd3; keyIn = 1'b0;
    doReset();
    check("R10 env after reset", envLevel, 12'd0);
    check("R10 out after reset", sampleOut, 12'd0);

    // R8 R9 R7 vector table in manual mode
    autoMode = 1'b0;
    for (int i = 0; i < 8; i++) begin
      keyEnable   = VEC[i][36];
      sampleIn    = VEC[i][35:24];
      manualScale = VEC[i][23:12];
      edges(1);
      check(VEC[i][36] ? "R8 scaled" : "R9 bypass", sampleOut, VEC[i][11:0]);
      check("R7 manual factor", scaleNow, VEC[i][23:12]);
    end

    // R1 R4 ramp at N=3
    autoMode = 1'b1; keyEnable = 1'b1; keyIn = 1'b1; rateCount = 8'd3;
    sampleIn = 12'd2048;
    doReset();
    edges(3);
    check("R1 no step before N+1", envLevel, 12'd0);
    edges(1);
    check("R1 first step", envLevel, 12'd1);
    edges(36);
    check("R1 period N+1", envLevel, 12'd10);

    // R2 new countdown taken at next reload
    rateCount = 8'd9;
    edges(4);
    check("R2 old period finishes", envLevel, 12'd11);
    edges(9);
    check("R2 new period not early", envLevel, 12'd11);
    edges(1);
    check("R2 new period", envLevel, 12'd12);

    // R3 stall below 3
    rateCount = 8'd2;
    doReset();
    edges(50);
    check("R3 stall N=2", envLevel, 12'd0);
    rateCount = 8'd0;
    edges(20);
    check("R3 stall N=0", envLevel, 12'd0);
    rateCount = 8'd3;
    edges(4);
    check("R3 leave stall early", envLevel, 12'd0);
    edges(1);
    check("R3 leave stall step", envLevel, 12'd1);

    // R4 saturate at full scale
    doReset();
    edges(16380);
    check("R4 reach full", envLevel, 12'd4095);
    edges(400);
    check("R4 hold full", envLevel, 12'd4095);
    check("R7 auto factor", scaleNow, 12'd4095);
    check("R8 full scale gain", sampleOut, 12'd2047);

    // R5 ramp down; phase is at a reload here
    keyIn = 1'b0;
    edges(4);
    check("R5 first down step", envLevel, 12'd4094);
    edges(36);
    check("R5 down rate", envLevel, 12'd4085);

    // R6 reverse in the cycle a step is pending
    edges(3);
    check("R6 before reversal", envLevel, 12'd4085);
    keyIn = 1'b1;
    edges(1);
    check("R6 reversal same cycle", envLevel, 12'd4086);
    keyIn = 1'b0;
    edges(4086 * 4 + 100);
    check("R5 hold zero", envLevel, 12'd0);
    check("R8 zero factor", sampleOut, 12'd0);

    // R10 reset mid-ramp
    keyIn = 1'b1;
    edges(40);
    check("R10 precondition", envLevel, 12'd10);
    doReset();
    check("R10 env cleared", envLevel, 12'd0);
    check("R10 out cleared", sampleOut, 12'd0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule